// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block collects interrupt requests from six internal source types, records each one in a pending flag, and ranks them by a fixed priority. It joins a priority chain with other devices through an enable-in and an enable-out line. A device further up the chain blocks this one by pulling enable-in low. This block in turn blocks the devices below it while it is requesting or being serviced.

During an acknowledge cycle the block decides once, on the first cycle of the strobe, whether it answers. If it answers, it marks the winning source as under service. It then presents a vector byte until the strobe drops. The vector is a programmed byte. Depending on a programmed inclusion level, it may also carry the winning source's type code.

Software writes the pending and under-service flags through a small command port and reads both back directly.

Sources are indexed 0 to 5 and their type codes are index plus one:

| Index | Code | Source          |
|-------|------|-----------------|
| 0     | 1    | device status   |
| 1     | 2    | I/O status      |
| 2     | 3    | transmit data   |
| 3     | 4    | transmit status |
| 4     | 5    | receive data    |
| 5     | 6    | receive status  |

Priority rises with the index.

The acknowledge sequencer has three states:
- **ST_IDLE** waits for the strobe.
- **ST_SERVE** means this device answered.
- **ST_PASS** means it let the cycle go by.

The transitions are:
- ST_IDLE to ST_SERVE when the strobe is high, enable-in is high and a candidate exists.
- ST_IDLE to ST_PASS when the strobe is high otherwise.
- ST_SERVE to ST_IDLE, and ST_PASS to ST_IDLE, when the strobe is low.
- Every other case holds the current state.

Top module: `int_chain_ctrl`

## Requirements
- R1: After reset all pending and under-service flags are zero, `int_req` and `vec_valid` are low, `vec_out` is zero, the programmed vector is zero and the inclusion level is 0.
- R2: A high `src_req` bit sets the matching pending flag at the next clock edge. The flag then stays set until a command clears it. In the same cycle, a request wins over a clearing command.
- R3: When `cmd_wr` is high, the selected bits (`cmd_sel` bit i is source i) are changed at the next edge according to `cmd_op`: 0 does nothing, 1 clears pending and under-service, 2 clears pending only, 3 sets pending.
- R4: A source is a candidate when its pending and enable bits are both set and no under-service flag is set at its own index or above. The winner is the candidate with the highest index.
- R5: `int_req` is high exactly when `iei` is high and at least one candidate exists.
- R6: `ieo` is low whenever `iei` is low or any under-service flag is set. It is also low while `ack_i` is high and a candidate exists. Otherwise it is high.
- R7: In ST_IDLE with `ack_i` high, the block answers only if `iei` is high and a candidate exists. Answering sets the winner's under-service flag and raises `vec_valid` from the next cycle. Otherwise it goes to ST_PASS and changes no flag. Both states return to ST_IDLE in the cycle after `ack_i` is seen low.
- R8: While `vec_valid` is high, `vec_out` is the programmed vector, with bits 3..1 replaced by the answered source's code when the code is at least 3 + level for levels 0 to 3. Levels 0, 1, 2 and 3 therefore admit codes from transmit data, transmit status, receive data and receive status upward. Levels 4 to 7 never replace bits. `vec_out` is zero while `vec_valid` is low.
- R9: A source whose enable bit is low still latches its pending flag, but it is not a candidate and raises no request.
- R10: `cfg_wr` loads the programmed vector and the inclusion level at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 6 | Per-source request pulses |
| src_en | input | 6 | Per-source enables |
| iei | input | 1 | Chain enable from higher-priority devices |
| ack_i | input | 1 | Acknowledge strobe, held for the whole cycle |
| cmd_wr | input | 1 | Flag command write |
| cmd_op | input | 2 | Flag command code |
| cmd_sel | input | 6 | Sources the command applies to |
| cfg_wr | input | 1 | Vector and level write |
| cfg_vector | input | 8 | Programmed vector byte |
| cfg_vis | input | 3 | Status inclusion level |
| int_req | output | 1 | Interrupt request |
| ieo | output | 1 | Chain enable to lower-priority devices |
| vec_valid | output | 1 | Vector presented |
| vec_out | output | 8 | Vector byte |
| ip_out | output | 6 | Pending flags |
| ius_out | output | 6 | Under-service flags |

## Verification
A wrong pending or under-service flag is visible at `ip_out` and `ius_out` in the very next cycle. It also reaches `int_req` and `ieo` at once, because both depend combinationally on those flags. A wrong sequencer state or a wrong latched code can only be seen during an acknowledge, through `vec_valid` and `vec_out`. The bench therefore runs acknowledges with the chain open and blocked, with nested service, and at every inclusion level.

// File: rtl/int_chain_pkg.sv
package int_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_PASS  = 2'd2
    } ack_state_e;

    typedef enum logic [1:0] {
        OP_NULL     = 2'd0,
        OP_CLR_BOTH = 2'd1,
        OP_CLR_IP   = 2'd2,
        OP_SET_IP   = 2'd3
    } flag_op_e;

endpackage

// File: rtl/ic_prio_pick.sv
module ic_prio_pick #(
    parameter int N  = 6,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  ip,
    input  logic [N-1:0]  en,
    input  logic [N-1:0]  ius,
    output logic          cand_any,
    output logic [IW-1:0] win_idx,
    output logic [N-1:0]  win_onehot
);

    logic [N-1:0] blocked;
    logic [N-1:0] cand;
    logic [N-1:0] higher_cand;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            if (g == N - 1) begin : g_top
                assign blocked[g]     = ius[g];
                assign higher_cand[g] = 1'b0;
            end else begin : g_low
                assign blocked[g]     = ius[g] | blocked[g+1];
                assign higher_cand[g] = cand[g+1] | higher_cand[g+1];
            end
            assign cand[g]       = ip[g] & en[g] & ~blocked[g];
            assign win_onehot[g] = cand[g] & ~higher_cand[g];
        end
    endgenerate

    assign cand_any = |cand;

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (win_onehot[i]) begin
                win_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/ic_flag_bank.sv
module ic_flag_bank
    import int_chain_pkg::*;
#(
    parameter int N = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          cmd_wr,
    input  flag_op_e      cmd_op,
    input  logic [N-1:0]  cmd_sel,
    input  logic [N-1:0]  serve_set,
    output logic [N-1:0]  ip,
    output logic [N-1:0]  ius
);

    logic clr_ip_cmd;
    logic clr_ius_cmd;
    logic set_ip_cmd;

    assign clr_ip_cmd  = cmd_wr && (cmd_op == OP_CLR_BOTH || cmd_op == OP_CLR_IP);
    assign clr_ius_cmd = cmd_wr && (cmd_op == OP_CLR_BOTH);
    assign set_ip_cmd  = cmd_wr && (cmd_op == OP_SET_IP);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ip[g]  <= 1'b0;
                    ius[g] <= 1'b0;
                end else begin
                    if (req[g] || (set_ip_cmd && cmd_sel[g])) begin
                        ip[g] <= 1'b1;
                    end else if (clr_ip_cmd && cmd_sel[g]) begin
                        ip[g] <= 1'b0;
                    end
                    if (serve_set[g]) begin
                        ius[g] <= 1'b1;
                    end else if (clr_ius_cmd && cmd_sel[g]) begin
                        ius[g] <= 1'b0;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ic_vec_build.sv
module ic_vec_build #(
    parameter int N    = 6,
    parameter int VW   = 8,
    parameter int CW   = 3,
    parameter int LW   = 3,
    parameter int NLVL = 4
) (
    input  logic [VW-1:0] pvec,
    input  logic [LW-1:0] vis,
    input  logic [CW-1:0] code,
    output logic [VW-1:0] vec
);

    localparam int BASE = N - NLVL + 1;

    logic include_code;

    always_comb begin
        include_code = 1'b0;
        if (int'(vis) < NLVL && code != '0) begin
            include_code = int'(code) >= BASE + int'(vis);
        end
    end

    always_comb begin
        vec = pvec;
        if (include_code) begin
            vec[CW:1] = code;
        end
    end

endmodule

// File: rtl/int_chain_ctrl.sv
module int_chain_ctrl
    import int_chain_pkg::*;
#(
    parameter int NSRC  = 6,
    parameter int VEC_W = 8,
    parameter int VIS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_req,
    input  logic [NSRC-1:0]  src_en,
    input  logic             iei,
    input  logic             ack_i,
    input  logic             cmd_wr,
    input  logic [1:0]       cmd_op,
    input  logic [NSRC-1:0]  cmd_sel,
    input  logic             cfg_wr,
    input  logic [VEC_W-1:0] cfg_vector,
    input  logic [VIS_W-1:0] cfg_vis,
    output logic             int_req,
    output logic             ieo,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out,
    output logic [NSRC-1:0]  ip_out,
    output logic [NSRC-1:0]  ius_out
);

    localparam int IW = $clog2(NSRC);
    localparam int CW = $clog2(NSRC + 1);

    ack_state_e       state_q;
    ack_state_e       state_d;
    logic [VEC_W-1:0] pvec_q;
    logic [VIS_W-1:0] vis_q;
    logic [CW-1:0]    code_q;

    logic [NSRC-1:0]  ip;
    logic [NSRC-1:0]  ius;
    logic             cand_any;
    logic [IW-1:0]    win_idx;
    logic [NSRC-1:0]  win_onehot;
    logic             serve_go;
    logic [NSRC-1:0]  serve_set;
    logic [VEC_W-1:0] built_vec;

    ic_prio_pick #(.N(NSRC), .IW(IW)) u_pick (
        .ip         (ip),
        .en         (src_en),
        .ius        (ius),
        .cand_any   (cand_any),
        .win_idx    (win_idx),
        .win_onehot (win_onehot)
    );

    ic_flag_bank #(.N(NSRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (src_req),
        .cmd_wr    (cmd_wr),
        .cmd_op    (flag_op_e'(cmd_op)),
        .cmd_sel   (cmd_sel),
        .serve_set (serve_set),
        .ip        (ip),
        .ius       (ius)
    );

    ic_vec_build #(.N(NSRC), .VW(VEC_W), .CW(CW), .LW(VIS_W)) u_vec (
        .pvec (pvec_q),
        .vis  (vis_q),
        .code (code_q),
        .vec  (built_vec)
    );

    assign serve_go  = (state_q == ST_IDLE) && ack_i && iei && cand_any;
    assign serve_set = {NSRC{serve_go}} & win_onehot;

    // State register, served-code latch and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            pvec_q  <= '0;
            vis_q   <= '0;
        end else begin
            state_q <= state_d;
            if (serve_go) begin
                code_q <= CW'(win_idx) + CW'(1);
            end
            if (cfg_wr) begin
                pvec_q <= cfg_vector;
                vis_q  <= cfg_vis;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ack_i) begin
                    state_d = serve_go ? ST_SERVE : ST_PASS;
                end
            end
            ST_SERVE, ST_PASS: begin
                if (!ack_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        int_req   = iei && cand_any;
        ieo       = iei && !(|ius) && !(ack_i && cand_any);
        vec_valid = (state_q == ST_SERVE);
        vec_out   = vec_valid ? built_vec : '0;
        ip_out    = ip;
        ius_out   = ius;
    end

endmodule

// File: rtl/int_chain_chk.sv
module int_chain_chk #(
    parameter int NSRC  = 6,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iei,
    input logic             ack_i,
    input logic             cmd_wr,
    input logic [1:0]       cmd_op,
    input logic [NSRC-1:0]  cmd_sel,
    input logic [NSRC-1:0]  src_en,
    input logic             int_req,
    input logic             ieo,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_out,
    input logic [NSRC-1:0]  ip_out,
    input logic [NSRC-1:0]  ius_out
);

    // R6: a closed chain above stays closed below
    a_r6_ieo_follows_iei: assert property (@(posedge clk) disable iff (!rst_n)
        !iei |-> !ieo);

    // R6: any service in progress closes the chain
    a_r6_ius_blocks_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (ius_out != '0) |-> !ieo);

    // R5: no request while the chain is closed
    a_r5_req_needs_iei: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> iei);

    // R9: a request implies some pending source is enabled
    a_r9_req_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((ip_out & src_en) != '0));

    // R7: answering only when the chain was open at the decision
    a_r7_serve_needs_iei: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(iei));

    // R7: strobe seen low ends the presentation
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !vec_valid);

    // R8: vector is zero when not presented
    a_r8_vec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_out == '0));

    // R3: the set-pending command takes effect
    a_r3_set_ip: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_op == 2'd3) |=> ((ip_out & $past(cmd_sel)) == $past(cmd_sel)));

endmodule

bind int_chain_ctrl int_chain_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iei       (iei),
    .ack_i     (ack_i),
    .cmd_wr    (cmd_wr),
    .cmd_op    (cmd_op),
    .cmd_sel   (cmd_sel),
    .src_en    (src_en),
    .int_req   (int_req),
    .ieo       (ieo),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .ip_out    (ip_out),
    .ius_out   (ius_out)
);

// File: tb/sim_int_chain_ctrl.sv
`timescale 1ns/1ps
module sim_int_chain_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] src_req = '0;
    logic [5:0] src_en = '0;
    logic       iei = 1'b0;
    logic       ack_i = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [5:0] cmd_sel = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_vector = '0;
    logic [2:0] cfg_vis = '0;
    logic       int_req;
    logic       ieo;
    logic       vec_valid;
    logic [7:0] vec_out;
    logic [5:0] ip_out;
    logic [5:0] ius_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    bit [5:0] m_ip, m_ius;
    int       m_state;   // 0 idle, 1 serve, 2 pass
    int       m_code;
    bit [7:0] m_pvec;
    int       m_vis;

    always #5 clk = ~clk;

    int_chain_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
        .iei(iei), .ack_i(ack_i), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
        .cmd_sel(cmd_sel), .cfg_wr(cfg_wr), .cfg_vector(cfg_vector),
        .cfg_vis(cfg_vis), .int_req(int_req), .ieo(ieo),
        .vec_valid(vec_valid), .vec_out(vec_out), .ip_out(ip_out),
        .ius_out(ius_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Scan from highest priority down: stop at any service, else first ready source
    function automatic int m_winner();
        for (int i = 5; i >= 0; i--) begin
            if (m_ius[i]) return -1;
            if (m_ip[i] && src_en[i]) return i;
        end
        return -1;
    endfunction

    function automatic bit [7:0] m_vector(int code);
        bit [7:0] v;
        int thr;
        v = m_pvec;
        thr = (m_vis <= 3) ? 3 + m_vis : 99;
        if (code >= thr) v[3:1] = code[2:0];
        return v;
    endfunction

    task automatic step();
        int w;
        bit mreq, mieo, mvalid;
        #2;
        w = m_winner();
        mreq   = iei && (w >= 0);
        mieo   = iei && (m_ius == 0) && !(ack_i && (w >= 0));
        mvalid = (m_state == 1);
        chk("R2 ip_out", 32'(ip_out), 32'(m_ip));
        chk("R7 ius_out", 32'(ius_out), 32'(m_ius));
        chk("R5 int_req", 32'(int_req), 32'(mreq));
        chk("R6 ieo", 32'(ieo), 32'(mieo));
        chk("R7 vec_valid", 32'(vec_valid), 32'(mvalid));
        chk("R8 vec_out", 32'(vec_out), mvalid ? 32'(m_vector(m_code)) : 32'd0);
        @(posedge clk);
        if (!rst_n) begin
            m_ip = '0; m_ius = '0; m_state = 0; m_code = 0; m_pvec = '0; m_vis = 0;
        end else begin
            for (int i = 0; i < 6; i++) begin
                if (cmd_wr && cmd_sel[i]) begin
                    if (cmd_op == 2'd1) begin m_ip[i] = 0; m_ius[i] = 0; end
                    if (cmd_op == 2'd2) m_ip[i] = 0;
                    if (cmd_op == 2'd3) m_ip[i] = 1;
                end
                if (src_req[i]) m_ip[i] = 1;
            end
            if (m_state == 0 && ack_i) begin
                if (iei && w >= 0) begin
                    m_ius[w] = 1; m_code = w + 1; m_state = 1;
                end else begin
                    m_state = 2;
                end
            end else if (m_state != 0 && !ack_i) begin
                m_state = 0;
            end
            if (cfg_wr) begin m_pvec = cfg_vector; m_vis = int'(cfg_vis); end
        end
        @(negedge clk);
        src_req = '0; cmd_wr = 0; cfg_wr = 0;
    endtask

    task automatic command(bit [1:0] op, bit [5:0] sel);
        cmd_wr = 1; cmd_op = op; cmd_sel = sel;
        step();
    endtask

    task automatic ack_begin();
        ack_i = 1;
        step();
    endtask

    task automatic ack_end();
        ack_i = 0;
        step();
        step();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R7 act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_ip = '0; m_ius = '0; m_state = 0; m_code = 0; m_pvec = '0; m_vis = 0;
        @(negedge clk);
        step();
        step();
        #1;
        // R1: reset state
        chk("R1 ip", 32'(ip_out), 0);
        chk("R1 ius", 32'(ius_out), 0);
        chk("R1 int_req", 32'(int_req), 0);
        chk("R1 vec_valid", 32'(vec_valid), 0);
        chk("R1 vec_out", 32'(vec_out), 0);
        rst_n = 1;
        iei = 1;
        src_en = 6'h3F;
        step();

        // R10: program vector 0xA1, level 0
        cfg_wr = 1; cfg_vector = 8'hA1; cfg_vis = 3'd0;
        step();

        // R2 R4: transmit data request, answered with code 3 in the vector
        src_req = 6'b000100;
        step();
        ack_begin();
        #1 chk("R8 vec with code 3", 32'(vec_out), 32'hA7);
        step();
        ack_end();

        // R4: lower source blocked by service, higher one nests
        src_req = 6'b000001;
        step();
        #1 chk("R4 lower blocked", 32'(int_req), 0);
        src_req = 6'b100000;
        step();
        #1 chk("R4 higher nests", 32'(int_req), 1);
        ack_begin();
        #1 chk("R8 vec with code 6", 32'(vec_out), 32'hAD);
        ack_end();

        // R3: clear both for sources 5 and 2, then device status answers unchanged vector
        command(2'd1, 6'b100100);
        #1 chk("R3 clear both", 32'(ius_out), 0);
        ack_begin();
        #1 chk("R8 code 1 excluded", 32'(vec_out), 32'hA1);
        ack_end();
        command(2'd1, 6'b000001);

        // R7: chain closed above, ack passes by
        iei = 0;
        src_req = 6'b010000;
        step();
        #1 chk("R6 ieo closed", 32'(ieo), 0);
        ack_begin();
        step();
        #1 chk("R7 pass no service", 32'(ius_out), 0);
        ack_end();
        iei = 1;
        step();

        // R6: strobe with candidate closes chain before answer
        ack_i = 1;
        #1 chk("R6 ieo during ack", 32'(ieo), 0);
        step();
        ack_end();
        command(2'd1, 6'b010000);

        // R9: disabled source latches but does not request
        src_en = 6'b101111;
        src_req = 6'b010000;
        step();
        #1 chk("R9 latched", 32'(ip_out), 32'h10);
        chk("R9 no req", 32'(int_req), 0);
        command(2'd2, 6'b010000);
        #1 chk("R3 clear ip only", 32'(ip_out), 0);
        src_en = 6'h3F;

        // R3: null command changes nothing; R2: request beats clear
        src_req = 6'b000010;
        step();
        command(2'd0, 6'h3F);
        #1 chk("R3 null", 32'(ip_out), 32'h02);
        src_req = 6'b000010;
        cmd_wr = 1; cmd_op = 2'd2; cmd_sel = 6'b000010;
        step();
        #1 chk("R2 request wins", 32'(ip_out), 32'h02);
        command(2'd2, 6'b000010);

        // R8: every inclusion level against transmit status (code 4)
        for (int lv = 0; lv < 8; lv++) begin
            cfg_wr = 1; cfg_vector = 8'h50; cfg_vis = 3'(lv);
            step();
            command(2'd3, 6'b001000);
            ack_begin();
            #1 chk("R8 level sweep", 32'(vec_out), (lv <= 1) ? 32'h58 : 32'h50);
            ack_end();
            command(2'd1, 6'b001000);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule